// File: doc/BRIEF.md
# Supply-Voltage Detector Control and Masking Logic

This block holds the control and status register of a supply-voltage detector, plus a small detection-level register that it guards. It connects to an 8-bit peripheral bus. Every write carries a per-bit strobe mask, so a single-bit write and a byte write go through the same path. The block takes a digital comparator result (supply below threshold), a detector enable, two option-mode bits and a reset-source indication. It produces a reset request and an interrupt request.

Software may change the detection level only after it has set a write-enable bit. That bit can be set only in the combined interrupt-and-reset mode. Hardware raises a read-only mask flag while write-enable is set, and it keeps the flag up for a settling window after an interrupt fires or after the level changes. While the mask flag is up, both requests are blocked. A reset from the detector itself keeps the write-enable bit and the level. Any other reset clears them.

Top module: `vdet_ctrl`

## Requirements
- R1: Reading address 0 returns write-enable at bit 7, mask flag at bit 1 and detection flag at bit 0, with bits 6..2 always zero. Reading address 1 returns the level register, zero-extended to 8 bits.
- R2: After a reset with `rst_from_det` low, address 0 reads 00h and the level register reads 0.
- R3: Bus writes to bits 1 and 0 of address 0 have no effect, because both bits are read-only.
- R4: Write-enable (bit 7) changes to 1 only when `opt_mode` is 2'b10. In modes 00, 01 and 11, writing 1 to it leaves it at 0. Writing 0 always clears it.
- R5: A write to address 1 changes the level register only while write-enable is 1.
- R6: The detection flag is 1 exactly when `det_en` and `cmp_below` are both 1. Otherwise it is 0.
- R7: The mask flag reads 1 for as long as write-enable is 1.
- R8: When an interrupt pulse fires, the mask flag stays 1 for exactly SETTLE_CYCLES cycles after that edge. A new trigger during the window restarts the count.
- R9: When an accepted write changes the level value, the mask flag stays 1 for SETTLE_CYCLES cycles after the write edge.
- R10: While the mask flag is 1, `rst_req` and `irq_req` are both 0. `irq_req` is a one-cycle pulse that fires when the detection flag rises while the mask is 0.
- R11: A reset with `rst_from_det` high keeps both write-enable and the level register.
- R12: Only bits whose strobe is 1 are updated: bit 7 of address 0, and bits LVL_W-1..0 of address 1.
- R13: `opt_mode` 00 allows only reset requests, 01 allows only interrupts, 10 allows both, and 11 allows neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_from_det | input | 1 | The current reset was caused by the detector |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = level register |
| bus_wdata | input | 8 | Write data |
| bus_wstrb | input | 8 | Per-bit write mask |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_below | input | 1 | Comparator: supply below threshold |
| det_en | input | 1 | Detector enabled |
| opt_mode | input | 2 | Option-mode bits |
| level_sel | output | LVL_W | Detection level to the analog side |
| rst_req | output | 1 | Reset request (level) |
| irq_req | output | 1 | Interrupt request (one-cycle pulse) |

## Verification
The bench builds the block with SETTLE_CYCLES = 5 and LVL_W = 2. The short window lets the bench observe the exact expiry edge and a restart in the middle of a window within a few cycles. The two-bit level field lets a partial strobe update one bit while the other keeps its value. The same short window is used to show that a level change extends the mask beyond the write-enable period.

// File: rtl/vdet_ctrl.sv
module vdet_ctrl #(
  parameter int SETTLE_CYCLES = 16,
  parameter int LVL_W         = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_from_det,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_wstrb,
  output logic [7:0]       bus_rdata,
  input  logic             cmp_below,
  input  logic             det_en,
  input  logic [1:0]       opt_mode,
  output logic [LVL_W-1:0] level_sel,
  output logic             rst_req,
  output logic             irq_req
);

  localparam int              CW       = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0]   CNT_LOAD = CW'(SETTLE_CYCLES);
  localparam logic [1:0]      MODE_RST = 2'b00;
  localparam logic [1:0]      MODE_IRQ = 2'b01;
  localparam logic [1:0]      MODE_ALL = 2'b10;

  logic             wen_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CW-1:0]    cnt_q;
  logic             flag_q;

  logic             flag, mask, rst_ok, irq_ok;
  logic             ctl_wr, lvl_wr, lvl_chg;
  logic [LVL_W-1:0] lvl_next;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata, bus_wstrb};

  assign flag   = det_en & cmp_below;
  assign mask   = wen_q | (cnt_q != '0);
  assign rst_ok = (opt_mode == MODE_RST) | (opt_mode == MODE_ALL);
  assign irq_ok = (opt_mode == MODE_IRQ) | (opt_mode == MODE_ALL);

  assign ctl_wr   = bus_wr & ~bus_addr & bus_wstrb[7];
  assign lvl_wr   = bus_wr & bus_addr & wen_q;
  assign lvl_next = (lvl_q & ~bus_wstrb[LVL_W-1:0]) |
                    (bus_wdata[LVL_W-1:0] & bus_wstrb[LVL_W-1:0]);
  assign lvl_chg  = lvl_wr & (lvl_next != lvl_q);

  assign irq_req = ~rst & irq_ok & ~mask & flag & ~flag_q;
  assign rst_req = ~rst & rst_ok & ~mask & flag;

  assign level_sel = lvl_q;
  assign bus_rdata = bus_addr ? {{(8-LVL_W){1'b0}}, lvl_q}
                              : {wen_q, 5'b0, mask, flag};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      if (!rst_from_det) begin
        wen_q <= 1'b0;
        lvl_q <= '0;
      end
    end else begin
      flag_q <= flag;
      if (ctl_wr)
        wen_q <= bus_wdata[7] & (opt_mode == MODE_ALL);
      if (lvl_wr)
        lvl_q <= lvl_next;
      if (irq_req || lvl_chg)
        cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_wen_only_in_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(wen_q) |-> $past(opt_mode) == MODE_ALL);

  a_r5_level_locked: assert property (@(posedge clk) disable iff (rst)
    !wen_q |=> $stable(lvl_q));

  a_r6_flag_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !bus_addr) |-> !bus_rdata[0]);

  a_r8_irq_opens_window: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> (bus_addr || bus_rdata[1]) && !rst_req);

  a_r10_irq_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

endmodule

// File: tb/vdet_ctrl_bench.sv
module vdet_ctrl_bench;
  localparam int SC = 5;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1, rst_from_det = 1'b0;
  logic          bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0]    bus_wdata = '0, bus_wstrb = '0, bus_rdata;
  logic          cmp_below = 1'b0, det_en = 1'b0;
  logic [1:0]    opt_mode = 2'b00;
  logic [LW-1:0] level_sel;
  logic          rst_req, irq_req;

  int n_chk = 0, n_bad = 0;

  vdet_ctrl #(.SETTLE_CYCLES(SC), .LVL_W(LW)) u_vdet_ctrl (
    .clk(clk), .rst(rst), .rst_from_det(rst_from_det),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .cmp_below(cmp_below), .det_en(det_en), .opt_mode(opt_mode),
    .level_sel(level_sel), .rst_req(rst_req), .irq_req(irq_req));

  always #4 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] s);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    tick();
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); chk("R2 ctrl after reset", v, 8'h00);
    rd(1'b1, v); chk("R2 level after reset", v, 8'h00);
    chk("R2 requests idle", {6'b0, rst_req, irq_req}, 8'h00);
  endtask

  task automatic t_wen_mode();
    logic [7:0] v;
    opt_mode = 2'b00; wr(1'b0, 8'h80, 8'hFF);
    rd(1'b0, v); chk("R4 mode00 blocks set", v, 8'h00);
    opt_mode = 2'b01; wr(1'b0, 8'h80, 8'hFF);
    rd(1'b0, v); chk("R4 mode01 blocks set", v, 8'h00);
    opt_mode = 2'b10; wr(1'b0, 8'h80, 8'hFF);
    rd(1'b0, v); chk("R4 R7 R1 set in mode10 with mask", v, 8'h82);
    wr(1'b0, 8'h7F, 8'h7F);
    rd(1'b0, v); chk("R3 R12 read-only and unstrobed bits", v, 8'h82);
    wr(1'b1, 8'h03, 8'h01);
    rd(1'b1, v); chk("R5 R12 partial level strobe", v, 8'h01);
    chk("R1 level_sel port", {6'b0, level_sel}, 8'h01);
    wr(1'b0, 8'h00, 8'h80);
    rd(1'b0, v); chk("R9 mask after level change", v, 8'h02);
    tick(3);
    rd(1'b0, v); chk("R9 mask still in window", v, 8'h02);
    tick();
    rd(1'b0, v); chk("R9 mask released", v, 8'h00);
    wr(1'b1, 8'h03, 8'hFF);
    rd(1'b1, v); chk("R5 level locked", v, 8'h01);
    rd(1'b0, v); chk("R5 no window without write", v, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    opt_mode = 2'b10; det_en = 1'b0;
    wr(1'b0, 8'h80, 8'h80);
    wr(1'b1, 8'h02, 8'hFF);
    tick(2);
    wr(1'b1, 8'h01, 8'hFF);
    wr(1'b0, 8'h00, 8'h80);
    tick(3);
    rd(1'b0, v); chk("R8 window restarted", v, 8'h02);
    tick();
    rd(1'b0, v); chk("R8 restarted window ends", v, 8'h00);
  endtask

  task automatic t_detect();
    logic [7:0] v;
    opt_mode = 2'b01; det_en = 1'b1; cmp_below = 1'b0;
    tick();
    rd(1'b0, v); chk("R6 flag clear above level", v, 8'h00);
    cmp_below = 1'b1; #1;
    chk("R10 irq pulse on rise", {7'b0, irq_req}, 8'h01);
    chk("R13 mode01 no reset", {7'b0, rst_req}, 8'h00);
    rd(1'b0, v); chk("R6 flag set below level", v, 8'h01);
    tick();
    rd(1'b0, v); chk("R8 mask after irq", v, 8'h03);
    chk("R10 irq single cycle", {7'b0, irq_req}, 8'h00);
    tick(4);
    rd(1'b0, v); chk("R8 mask last cycle", v, 8'h03);
    tick();
    rd(1'b0, v); chk("R8 mask released", v, 8'h01);
    opt_mode = 2'b11; #1;
    chk("R13 mode11 nothing", {6'b0, rst_req, irq_req}, 8'h00);
    opt_mode = 2'b00; #1;
    chk("R13 mode00 reset", {6'b0, rst_req, irq_req}, 8'h02);
    opt_mode = 2'b10; #1;
    chk("R13 mode10 reset", {7'b0, rst_req}, 8'h01);
    wr(1'b0, 8'h80, 8'h80);
    chk("R10 R7 reset blocked by mask", {7'b0, rst_req}, 8'h00);
    cmp_below = 1'b0; tick();
    cmp_below = 1'b1; #1;
    chk("R10 irq blocked by mask", {7'b0, irq_req}, 8'h00);
    tick();
    wr(1'b0, 8'h00, 8'h80);
    chk("R10 reset after mask drops", {7'b0, rst_req}, 8'h01);
    det_en = 1'b0; #1;
    rd(1'b0, v); chk("R6 flag clear when disabled", v, 8'h00);
    chk("R6 no reset when disabled", {7'b0, rst_req}, 8'h00);
    cmp_below = 1'b0;
  endtask

  task automatic t_det_reset();
    logic [7:0] v;
    opt_mode = 2'b10;
    wr(1'b0, 8'h80, 8'h80);
    wr(1'b1, 8'h02, 8'hFF);
    rst = 1'b1; rst_from_det = 1'b1; tick(2); rst = 1'b0; rst_from_det = 1'b0;
    rd(1'b0, v); chk("R11 write-enable kept", v, 8'h82);
    rd(1'b1, v); chk("R11 level kept", v, 8'h02);
    rst = 1'b1; tick(2); rst = 1'b0;
    rd(1'b0, v); chk("R2 ctrl cleared", v, 8'h00);
    rd(1'b1, v); chk("R2 level cleared", v, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_wen_mode();
    t_restart();
    t_detect();
    t_det_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule